// File: doc/BRIEF.md
# Three-Wire Serial Register Access Master

This block lets on-chip logic read and write the 16-bit configuration registers of an external switch-like device over a slow three-wire link. The link has a select line, a serial clock and one bidirectional data line. The host side is a small request port: a request carries an operation (read or write), a register address and, for writes, 16 bits of data. Completion is a single-cycle done pulse, which carries the read result on the same cycle.

The two operations use different frames. A write raises the select line, sends a short command that carries the address and the data, and drops the select line at the end. A read keeps the select line low and sends a long command that begins with a run of ones. It then releases the data line and gives two idle clock pulses. After that it clocks in 32 bits. The device answers with two neighbouring registers at once, and bit 0 of the address decides which half is returned. Every transaction ends with two more clock pulses, after which all three pins are released.

The link is slow, so the durations of the clock-low, clock-high and data-setup intervals are parameters counted in system clock cycles. `EDGE_CYC` sets the clock-low and clock-high intervals and `SETUP_CYC` sets the data setup time. Both must be at least 1.

Top module: `serial_cfg_master`

## Requirements
- R1: A read sends 46 bits, most significant first, with `cs_o` held low for the whole transaction. The bits are 32 ones, then 0,1,1,0,0,0,0, then address bits 6 down to 0. Address bit 7 is not sent.
- R2: A write sends 27 bits, most significant first, with `cs_o` high from the first busy cycle through the end of the frame. The bits are 1,0,1, then address bits 7 down to 0, then data bits 15 down to 0.
- R3: Each sent bit takes three intervals. First the clock is low for `EDGE_CYC` cycles while the previous data value holds. Then the new bit appears on `sd_o` with the clock still low, for `SETUP_CYC` cycles. Then the clock is high for `EDGE_CYC` cycles. `sd_o` never changes while `sck_o` is high.
- R4: After a read frame, a clock-low interval of `EDGE_CYC` cycles follows. Then `sd_oe` drops together with the first of two idle clock pulses, each pulse being `EDGE_CYC` cycles high followed by `EDGE_CYC` cycles low. Next comes a clock-low lead interval of `EDGE_CYC` cycles, then 32 input bits. Each input bit is `EDGE_CYC` cycles low and then `EDGE_CYC` cycles high, and `sd_i` is sampled on the last low cycle, before the rising edge. A final clock-low interval of `EDGE_CYC` cycles closes the capture.
- R5: The read result is the first 16 bits received when address bit 0 is 1, and the last 16 bits received when it is 0.
- R6: After the data phase, every transaction gives two trailing pulses of `EDGE_CYC` high then `EDGE_CYC` low. For a write, `cs_o` falls only after the clock has been low for `EDGE_CYC` cycles, on the cycle the first trailing pulse rises.
- R7: A transaction starts with all three pins driven low for `EDGE_CYC` cycles, with `cs_o` already at its level for the operation. While the block is idle, all three output enables are low.
- R8: `req_ready` is high only while idle. A request presented while busy is ignored. `rsp_done` is high for exactly one cycle, the first idle cycle after a transaction. `rsp_rdata` is valid on that cycle, and is zero for a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Register address |
| req_wdata | input | 16 | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read result, valid with `rsp_done` |
| cs_o | output | 1 | Select line value |
| cs_oe | output | 1 | Select line output enable |
| sck_o | output | 1 | Serial clock value |
| sck_oe | output | 1 | Serial clock output enable |
| sd_o | output | 1 | Data line value driven by the block |
| sd_oe | output | 1 | Data line output enable |
| sd_i | input | 1 | Data line value seen at the pin |

## Verification
The hardest thing to observe is the exact sampling cycle of the 32 read bits, because a design that samples one cycle early or late would still read a plausible word. The bench drives `sd_i` with the inverse of each bit on every cycle except the last low cycle before each rising edge. Any other sampling point therefore corrupts the returned half. Requests are also presented in the middle of a busy transaction with the opposite operation, and the cycle-exact pin comparison shows that they leave the frame untouched.

// File: rtl/scfg_pkg.sv
package scfg_pkg;
    localparam int REG_W       = 16;
    localparam int ADDR_W      = 8;
    localparam int RD_ADDR_W   = 7;
    localparam int PREAMBLE_W  = 32;
    localparam int RD_BITS     = 46;
    localparam int WR_BITS     = 27;
    localparam int FRAME_W     = RD_BITS;
    localparam int RX_BITS     = 2 * REG_W;
    localparam int GAP_PULSES  = 2;
    localparam int TAIL_PULSES = 2;
    localparam int CNT_W       = $clog2(FRAME_W + 1);

    typedef enum logic [3:0] {
        ST_IDLE, ST_LEAD, ST_TX_LO, ST_TX_SU, ST_TX_HI, ST_TX_END,
        ST_GAP_HI, ST_GAP_LO, ST_RX_LEAD, ST_RX_LO, ST_RX_HI, ST_RX_END,
        ST_TAIL_HI, ST_TAIL_LO
    } phase_e;

    typedef struct packed {
        phase_e             st;
        logic               wr;
        logic               odd;
        logic [FRAME_W-1:0] sh;
        logic [CNT_W-1:0]   cnt;
        logic [RX_BITS-1:0] rx;
        logic               cs;
        logic               sck;
        logic               sd;
        logic               cs_oe;
        logic               sck_oe;
        logic               sd_oe;
        logic               done;
        logic [REG_W-1:0]   rdata;
    } ctl_t;
endpackage

// File: rtl/scfg_frame_build.sv
module scfg_frame_build
    import scfg_pkg::*;
(
    input  logic               is_wr,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [REG_W-1:0]   wdata,
    output logic [FRAME_W-1:0] frame,
    output logic [CNT_W-1:0]   nbits
);
    localparam int WR_PAD = FRAME_W - WR_BITS;

    always_comb begin
        if (is_wr) begin
            frame = {3'b101, addr, wdata, {WR_PAD{1'b0}}};
            nbits = CNT_W'(WR_BITS);
        end else begin
            frame = {{PREAMBLE_W{1'b1}}, 7'b0110000, addr[RD_ADDR_W-1:0]};
            nbits = CNT_W'(RD_BITS);
        end
    end
endmodule

// File: rtl/scfg_phase_timer.sv
module scfg_phase_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] len,
    output logic         expired
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = len - W'(1);
        else if (cnt_q != '0)
            cnt_d = cnt_q - W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/scfg_half_pick.sv
module scfg_half_pick
    import scfg_pkg::*;
(
    input  logic [RX_BITS-1:0] word,
    input  logic               odd,
    output logic [REG_W-1:0]   half
);
    assign half = odd ? word[RX_BITS-1 -: REG_W] : word[REG_W-1:0];
endmodule

// File: rtl/serial_cfg_master.sv
module serial_cfg_master
    import scfg_pkg::*;
#(
    parameter int EDGE_CYC  = 300,
    parameter int SETUP_CYC = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [REG_W-1:0]  req_wdata,
    output logic              rsp_done,
    output logic [REG_W-1:0]  rsp_rdata,
    output logic              cs_o,
    output logic              cs_oe,
    output logic              sck_o,
    output logic              sck_oe,
    output logic              sd_o,
    output logic              sd_oe,
    input  logic              sd_i
);
    localparam int TMAX = (EDGE_CYC > SETUP_CYC) ? EDGE_CYC : SETUP_CYC;
    localparam int TW   = $clog2(TMAX + 1);
    localparam logic [TW-1:0] EDGE_L  = TW'(EDGE_CYC);
    localparam logic [TW-1:0] SETUP_L = TW'(SETUP_CYC);

    ctl_t d, q;
    logic               t_load, t_exp, in_tx;
    logic [TW-1:0]      t_len;
    logic [FRAME_W-1:0] frame;
    logic [CNT_W-1:0]   nbits;
    logic [REG_W-1:0]   half;

    scfg_frame_build i_frame (
        .is_wr(req_write), .addr(req_addr), .wdata(req_wdata),
        .frame(frame), .nbits(nbits)
    );

    scfg_phase_timer #(.W(TW)) i_timer (
        .clk(clk), .rst_n(rst_n), .load(t_load), .len(t_len), .expired(t_exp)
    );

    scfg_half_pick i_half (.word(q.rx), .odd(q.odd), .half(half));

    always_comb begin
        d      = q;
        d.done = 1'b0;
        t_load = 1'b0;
        t_len  = EDGE_L;
        unique case (q.st)
            ST_IDLE: if (req_valid) begin
                d.st = ST_LEAD; d.wr = req_write; d.odd = req_addr[0];
                d.sh = frame;   d.cnt = nbits;    t_load = 1'b1;
            end
            ST_LEAD: if (t_exp) begin d.st = ST_TX_LO; t_load = 1'b1; end
            ST_TX_LO: if (t_exp) begin
                d.st = ST_TX_SU; t_load = 1'b1; t_len = SETUP_L;
                d.sd = q.sh[FRAME_W-1];
                d.sh = q.sh << 1;
            end
            ST_TX_SU: if (t_exp) begin d.st = ST_TX_HI; t_load = 1'b1; end
            ST_TX_HI: if (t_exp) begin
                t_load = 1'b1;
                if (q.cnt == CNT_W'(1)) d.st = ST_TX_END;
                else begin d.cnt = q.cnt - CNT_W'(1); d.st = ST_TX_LO; end
            end
            ST_TX_END: if (t_exp) begin
                t_load = 1'b1;
                d.cnt  = q.wr ? CNT_W'(TAIL_PULSES) : CNT_W'(GAP_PULSES);
                d.st   = q.wr ? ST_TAIL_HI : ST_GAP_HI;
            end
            ST_GAP_HI: if (t_exp) begin d.st = ST_GAP_LO; t_load = 1'b1; end
            ST_GAP_LO: if (t_exp) begin
                t_load = 1'b1;
                if (q.cnt == CNT_W'(1)) begin d.st = ST_RX_LEAD; d.cnt = CNT_W'(RX_BITS); end
                else begin d.cnt = q.cnt - CNT_W'(1); d.st = ST_GAP_HI; end
            end
            ST_RX_LEAD: if (t_exp) begin d.st = ST_RX_LO; t_load = 1'b1; end
            ST_RX_LO: if (t_exp) begin
                d.st = ST_RX_HI; t_load = 1'b1;
                d.rx = {q.rx[RX_BITS-2:0], sd_i};
            end
            ST_RX_HI: if (t_exp) begin
                t_load = 1'b1;
                if (q.cnt == CNT_W'(1)) d.st = ST_RX_END;
                else begin d.cnt = q.cnt - CNT_W'(1); d.st = ST_RX_LO; end
            end
            ST_RX_END: if (t_exp) begin
                d.st = ST_TAIL_HI; t_load = 1'b1; d.cnt = CNT_W'(TAIL_PULSES);
            end
            ST_TAIL_HI: if (t_exp) begin d.st = ST_TAIL_LO; t_load = 1'b1; end
            ST_TAIL_LO: if (t_exp) begin
                if (q.cnt == CNT_W'(1)) begin
                    d.st    = ST_IDLE;
                    d.done  = 1'b1;
                    d.rdata = q.wr ? '0 : half;
                end else begin
                    d.cnt = q.cnt - CNT_W'(1); d.st = ST_TAIL_HI; t_load = 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase

        // pin levels for the phase being entered
        in_tx = (d.st inside {ST_LEAD, ST_TX_LO, ST_TX_SU, ST_TX_HI, ST_TX_END});
        if (d.st == ST_IDLE) begin
            d.cs_oe = 1'b0; d.sck_oe = 1'b0; d.sd_oe = 1'b0;
            d.cs    = 1'b0; d.sck    = 1'b0; d.sd    = 1'b0;
        end else begin
            d.cs_oe  = 1'b1;
            d.sck_oe = 1'b1;
            d.cs     = d.wr & in_tx;
            d.sck    = (d.st inside {ST_TX_HI, ST_GAP_HI, ST_RX_HI, ST_TAIL_HI});
            d.sd_oe  = d.wr | in_tx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign req_ready = (q.st == ST_IDLE);
    assign rsp_done  = q.done;
    assign rsp_rdata = q.rdata;
    assign cs_o      = q.cs;
    assign cs_oe     = q.cs_oe;
    assign sck_o     = q.sck;
    assign sck_oe    = q.sck_oe;
    assign sd_o      = q.sd;
    assign sd_oe     = q.sd_oe;
endmodule

// File: rtl/scfg_checker.sv
module scfg_checker (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic req_write,
    input logic rsp_done,
    input logic cs_o,
    input logic cs_oe,
    input logic sck_o,
    input logic sck_oe,
    input logic sd_o,
    input logic sd_oe
);
    logic rd_busy_q;

    always_ff @(posedge clk) begin
        if (!rst_n) rd_busy_q <= 1'b0;
        else begin
            if (rsp_done) rd_busy_q <= 1'b0;
            if (req_valid && req_ready) rd_busy_q <= !req_write;
        end
    end

    AST_RD_CS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        rd_busy_q |-> !cs_o);                                            // R1
    AST_WR_CS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_o) |-> $past(req_valid && req_ready && req_write));     // R2
    AST_SD_STABLE_HI: assert property (@(posedge clk) disable iff (!rst_n)
        sck_o |-> $stable(sd_o));                                        // R3
    AST_TURN_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sd_oe) && !req_ready) |-> $rose(sck_o));                  // R4
    AST_CS_FALL_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_o) |-> $past(sck_oe && !sck_o));                        // R6
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !(cs_oe || sck_oe || sd_oe));                      // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);                                         // R8
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);                        // R8
endmodule

bind serial_cfg_master scfg_checker i_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .rsp_done(rsp_done), .cs_o(cs_o), .cs_oe(cs_oe),
    .sck_o(sck_o), .sck_oe(sck_oe), .sd_o(sd_o), .sd_oe(sd_oe)
);

// File: tb/test_serial_cfg_master.sv
`timescale 1ns/1ps
module test_serial_cfg_master;
    localparam int E = 3;
    localparam int S = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, sd_i = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ready, rsp_done, cs_o, cs_oe, sck_o, sck_oe, sd_o, sd_oe;
    logic [15:0] rsp_rdata;

    int checks = 0, failures = 0;

    // expected per-cycle: {done, cs_oe, cs, sck_oe, sck, sd_oe, sd}
    logic [6:0]  exp_q[$];
    logic        drv_q[$];
    logic [15:0] rd_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    serial_cfg_master #(.EDGE_CYC(E), .SETUP_CYC(S)) i_serial_cfg_master (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .cs_o(cs_o), .cs_oe(cs_oe),
        .sck_o(sck_o), .sck_oe(sck_oe), .sd_o(sd_o), .sd_oe(sd_oe), .sd_i(sd_i)
    );

    task automatic chk(bit ok, string tg, string what, logic [31:0] act, logic [31:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h at %0t", tg, what, act, expv, $time);
        end
    endtask

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    task automatic put(int n, logic [5:0] pins, string tg, logic dv);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back({1'b0, pins}); drv_q.push_back(dv);
            rd_q.push_back(16'h0);         tag_q.push_back(tg);
        end
    endtask

    // one cycle: compare at the falling edge, then set the device's data bit
    task automatic tick();
        logic [6:0] e, a, m;
        logic dv, idle;
        logic [15:0] r;
        string tg;
        @(negedge clk);
        idle = (exp_q.size() == 0);
        if (idle) begin e = '0; dv = 1'b0; r = '0; tg = "R7"; end
        else begin
            e = exp_q.pop_front(); dv = drv_q.pop_front();
            r = rd_q.pop_front();  tg = tag_q.pop_front();
        end
        a = {rsp_done, cs_oe, cs_o, sck_oe, sck_o, sd_oe, sd_o};
        m = {1'b1, 1'b1, e[5], 1'b1, e[3], 1'b1, e[1]};
        chk((a & m) == (e & m), tg, "pins", 32'(a), 32'(e));
        chk(req_ready == (idle || e[6]), "R8", "ready", 32'(req_ready), 32'(idle || e[6]));
        if (e[6]) chk(rsp_rdata == r, "R5", "rdata", 32'(rsp_rdata), 32'(r));
        sd_i = dv;
    endtask

    task automatic build(bit wr, logic [7:0] a, logic [15:0] wd, logic [31:0] w);
        bit bits[$];
        bit cv, cur;
        string ft;
        cv = wr;
        ft = wr ? "R2" : "R1";
        if (wr) begin
            bits = '{1'b1, 1'b0, 1'b1};
            for (int i = 7; i >= 0; i--)  bits.push_back(a[i]);
            for (int i = 15; i >= 0; i--) bits.push_back(wd[i]);
        end else begin
            for (int i = 0; i < 32; i++) bits.push_back(1'b1);
            bits.push_back(0); bits.push_back(1); bits.push_back(1); bits.push_back(0);
            bits.push_back(0); bits.push_back(0); bits.push_back(0);
            for (int i = 6; i >= 0; i--) bits.push_back(a[i]);
        end
        put(E, {2'b10 | 2'(cv), 2'b10, 2'b10}, "R7", 1'b0);            // lead
        cur = 1'b0;
        foreach (bits[i]) begin
            put(E, {1'b1, cv, 2'b10, 1'b1, cur}, "R3", 1'b0);
            cur = bits[i];
            put(S, {1'b1, cv, 2'b10, 1'b1, cur}, ft, 1'b0);
            put(E, {1'b1, cv, 2'b11, 1'b1, cur}, "R3", 1'b0);
        end
        put(E, {1'b1, cv, 2'b10, 1'b1, cur}, ft, 1'b0);                // frame close
        if (!wr) begin
            for (int p = 0; p < 2; p++) begin
                put(E, 6'b101100, "R4", 1'b0);
                put(E, 6'b101000, "R4", 1'b0);
            end
            put(E, 6'b101000, "R4", 1'b0);
            for (int i = 31; i >= 0; i--) begin
                put(E - 1, 6'b101000, "R4", ~w[i]);
                put(1,     6'b101000, "R4",  w[i]);
                put(E,     6'b101100, "R4", ~w[i]);
            end
            put(E, 6'b101000, "R4", 1'b0);
        end
        for (int p = 0; p < 2; p++) begin
            put(E, {4'b1011, wr, cur}, "R6", 1'b0);
            put(E, {4'b1010, wr, cur}, "R6", 1'b0);
        end
        exp_q.push_back(7'b1000000); drv_q.push_back(1'b0);
        rd_q.push_back(wr ? 16'h0 : (a[0] ? w[31:16] : w[15:0]));
        tag_q.push_back("R8");
    endtask

    task automatic run(bit wr, logic [7:0] a, logic [15:0] wd, logic [31:0] w, bit poke);
        int k;
        tick();
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
        build(wr, a, wd, w);
        tick();
        req_valid = 1'b0;
        k = 0;
        while (exp_q.size() > 0) begin
            tick();
            k++;
            // R8: requests while busy must be ignored
            req_valid = poke && (k > 5) && (k < 20);
            req_write = !wr; req_addr = ~a; req_wdata = ~wd;
        end
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL R8 watchdog: cycles=%0d expected<%0d", 100000, 100000);
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick(); // R7 reset state: pins released, ready high
        run(1'b1, 8'hA5, 16'hC3E1, 32'h0, 1'b0);        // R2 write
        run(1'b0, 8'h03, 16'h0,    32'h1234ABCD, 1'b0); // R5 odd -> upper
        run(1'b0, 8'h04, 16'h0,    32'h1234ABCD, 1'b0); // R5 even -> lower
        run(1'b0, 8'h81, 16'h0,    32'h8001FFFE, 1'b1); // R1 bit 7 unsent, R8 busy poke
        run(1'b1, 8'hFF, 16'h0000, 32'h0, 1'b1);        // R6 write corner + poke
        run(1'b1, 8'h00, 16'hFFFF, 32'h0, 1'b0);
        run(1'b0, 8'h7E, 16'h0,    32'h5A5AA5A5, 1'b0);
        repeat (4) tick();
        summary();
    end
endmodule